// File: doc/BRIEF.md
# Master Clock Monitor and Mute Controller

This block keeps watch over a free-running high-frequency master clock that has no fixed phase relation to the system clock. A counter in the master clock domain advances on every rising master clock edge and carries its value across to the system domain in Gray code. On the system side, a fixed window of system clock cycles repeats without pause. At the end of each window the block publishes how many master clock edges arrived during that window, and it compares that number against programmable lower and upper limits.

An out-of-range result is recorded in a bank of sticky error flags. The same bank also records single-cycle pulses from three other error sources: serial protocol errors, data underruns and data overruns. Software clears any flag by presenting a one on the matching bit of the clear input. Two separate enable masks choose which flags drive the mute output and which drive the interrupt line. An external mute request can force mute regardless of the flags, and the active level of the mute output is selectable.

Top module: `mclk_guard`

## Requirements
- R1: At the end of every window of WIN_LEN system clock cycles (32 by default), `meas_cnt` is loaded with the number of rising `mclk` edges in that window, within ±1 for the asynchronous phase, and `meas_vld` pulses high for one cycle. The first window after reset is discarded.
- R2: Between two `meas_vld` pulses, `meas_cnt` holds its value.
- R3: Error flag bit 3 (clock range) is set in the cycle after a window result is published if the count is below `cnt_min` or above `cnt_max`. The limits are inclusive, so a count inside them sets nothing.
- R4: A one-cycle pulse sets a flag that then stays set: `err_proto` sets bit 0, `err_under` sets bit 1 and `err_over` sets bit 2. The flag is visible on `err_flags` after the next clock edge.
- R5: A one on bit i of `flag_clr` clears flag i at the next edge. A set and a clear of the same bit in the same cycle leaves the flag set. Clearing a bit that is already zero changes nothing.
- R6: Mute is active whenever any flag is set whose bit in `mute_en` is one, or while `ext_mute` is high. An active mute goes straight to the output without a register.
- R7: With `mute_pol` = 1, `mute_out` is high when mute is active. With `mute_pol` = 0, `mute_out` is low when mute is active.
- R8: `irq` is high whenever any flag is set whose bit in `irq_en` is one. It does not depend on `mute_en`.
- R9: After reset, `err_flags`, `meas_cnt`, `meas_vld` and `irq` are zero.
- R10: When `mclk` stops, the published count is 0, and bit 3 is set if `cnt_min` is above 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset, also carried into the master clock domain |
| mclk | input | 1 | Asynchronous master clock under observation |
| err_proto | input | 1 | Serial protocol error pulse |
| err_under | input | 1 | Data underrun pulse |
| err_over | input | 1 | Data overrun pulse |
| ext_mute | input | 1 | External mute request, active high |
| cnt_min | input | CNT_W | Lowest acceptable edge count per window |
| cnt_max | input | CNT_W | Highest acceptable edge count per window |
| mute_en | input | 4 | Flags allowed to drive mute |
| irq_en | input | 4 | Flags allowed to drive the interrupt |
| mute_pol | input | 1 | 1: mute drives the output high; 0: mute drives it low |
| flag_clr | input | 4 | Write-one-to-clear for the flags |
| meas_cnt | output | CNT_W | Edge count of the last completed window |
| meas_vld | output | 1 | One-cycle pulse when `meas_cnt` updates |
| err_flags | output | 4 | Sticky flags: bit 0 protocol, bit 1 underrun, bit 2 overrun, bit 3 range |
| mute_out | output | 1 | Mute output at the selected level |
| irq | output | 1 | Interrupt request, level |

## Verification
The bench builds the block with its default parameters: a 32-cycle window, an 8-bit count and two synchronizer stages. The fastest master clock it drives runs at twice the system rate and gives 64 edges per window, so the count stays well away from wrapping its 8-bit field. The bench then halves the master clock rate twice (32 and 16 edges per window) and finally stops it. This lets the same limits cover an in-range case, a below-minimum case and the stopped-clock case.

// File: rtl/mgd_pkg.sv
package mgd_pkg;

    localparam int NUM_ERR   = 4;
    localparam int ERR_PROTO = 0;
    localparam int ERR_UNDER = 1;
    localparam int ERR_OVER  = 2;
    localparam int ERR_RANGE = 3;

    typedef logic [NUM_ERR-1:0] err_vec_t;

    // outcome of comparing one window count against the limits
    typedef struct packed {
        logic below;
        logic above;
    } range_t;

    function automatic logic [31:0] to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] from_gray(input logic [31:0] g);
        logic [31:0] b;
        for (int i = 0; i < 32; i++) begin
            b[i] = ^(g >> i);
        end
        return b;
    endfunction

endpackage

// File: rtl/mgd_edge_counter.sv
module mgd_edge_counter #(
    parameter int CNT_W = 8
) (
    input  logic             mclk,
    input  logic             rst,
    output logic [CNT_W-1:0] gray_q
);
    import mgd_pkg::*;

    logic [1:0]       rst_sync;
    logic             mclk_rst;
    logic [CNT_W-1:0] bin_q;
    logic [CNT_W-1:0] bin_nxt;

    // bring the system reset into the master clock domain
    always_ff @(posedge mclk) begin
        rst_sync <= {rst_sync[0], rst};
    end
    assign mclk_rst = rst_sync[1];

    assign bin_nxt = bin_q + CNT_W'(1);

    always_ff @(posedge mclk) begin
        if (mclk_rst) begin
            bin_q  <= '0;
            gray_q <= '0;
        end else begin
            bin_q  <= bin_nxt;
            gray_q <= CNT_W'(to_gray(32'(bin_nxt)));
        end
    end

    // the value crossing domains may change by at most one bit per edge
    assert_gray_step_R1: assert property (@(posedge mclk) disable iff (mclk_rst !== 1'b0)
        $onehot0(gray_q ^ $past(gray_q)));

endmodule

// File: rtl/mgd_window_meter.sv
module mgd_window_meter #(
    parameter int CNT_W       = 8,
    parameter int WIN_LEN     = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] mclk_gray,
    input  logic [CNT_W-1:0] cnt_min,
    input  logic [CNT_W-1:0] cnt_max,
    output logic [CNT_W-1:0] meas_cnt,
    output logic             meas_vld,
    output logic             range_hit
);
    import mgd_pkg::*;

    localparam int WIN_W = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;

    logic [CNT_W-1:0] sync_q [SYNC_STAGES];
    logic [CNT_W-1:0] cur_bin;
    logic [CNT_W-1:0] snap_q;
    logic [CNT_W-1:0] diff;
    logic [WIN_W-1:0] win_q;
    logic             win_end;
    logic             primed_q;
    range_t           chk;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
        end else begin
            sync_q[0] <= mclk_gray;
            for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
        end
    end

    assign cur_bin   = CNT_W'(from_gray(32'(sync_q[SYNC_STAGES-1])));
    assign win_end   = (win_q == WIN_W'(WIN_LEN - 1));
    assign diff      = cur_bin - snap_q;
    assign chk.below = (diff < cnt_min);
    assign chk.above = (diff > cnt_max);

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q     <= '0;
            snap_q    <= '0;
            primed_q  <= 1'b0;
            meas_cnt  <= '0;
            meas_vld  <= 1'b0;
            range_hit <= 1'b0;
        end else begin
            win_q     <= win_end ? '0 : win_q + WIN_W'(1);
            meas_vld  <= 1'b0;
            range_hit <= 1'b0;
            if (win_end) begin
                snap_q   <= cur_bin;
                primed_q <= 1'b1;
                if (primed_q) begin
                    meas_cnt  <= diff;
                    meas_vld  <= 1'b1;
                    range_hit <= chk.below | chk.above;
                end
            end
        end
    end

    assert_vld_pulse_R1: assert property (@(posedge clk) disable iff (rst)
        meas_vld |=> !meas_vld);

    assert_count_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !meas_vld |-> $stable(meas_cnt));

    assert_range_with_result_R3: assert property (@(posedge clk) disable iff (rst)
        range_hit |-> meas_vld);

endmodule

// File: rtl/mgd_err_combiner.sv
module mgd_err_combiner (
    input  logic              clk,
    input  logic              rst,
    input  mgd_pkg::err_vec_t set_vec,
    input  mgd_pkg::err_vec_t clr_vec,
    input  mgd_pkg::err_vec_t mute_en,
    input  mgd_pkg::err_vec_t irq_en,
    input  logic              ext_mute,
    input  logic              mute_pol,
    output mgd_pkg::err_vec_t flags,
    output logic              mute_out,
    output logic              irq
);
    import mgd_pkg::*;

    logic mute_active;

    // set has priority over a clear of the same bit
    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= (flags & ~clr_vec) | set_vec;
    end

    assign mute_active = (|(flags & mute_en)) | ext_mute;
    assign mute_out    = mute_pol ? mute_active : ~mute_active;
    assign irq         = |(flags & irq_en);

    assert_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        (($past(flags) & ~$past(clr_vec)) & ~flags) == '0);

    assert_set_wins_R5: assert property (@(posedge clk) disable iff (rst)
        ($past(set_vec) & ~flags) == '0);

endmodule

// File: rtl/mclk_guard.sv
module mclk_guard #(
    parameter int CNT_W       = 8,
    parameter int WIN_LEN     = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mclk,
    input  logic             err_proto,
    input  logic             err_under,
    input  logic             err_over,
    input  logic             ext_mute,
    input  logic [CNT_W-1:0] cnt_min,
    input  logic [CNT_W-1:0] cnt_max,
    input  logic [3:0]       mute_en,
    input  logic [3:0]       irq_en,
    input  logic             mute_pol,
    input  logic [3:0]       flag_clr,
    output logic [CNT_W-1:0] meas_cnt,
    output logic             meas_vld,
    output logic [3:0]       err_flags,
    output logic             mute_out,
    output logic             irq
);
    import mgd_pkg::*;

    logic [CNT_W-1:0] mclk_gray;
    logic             range_hit;
    err_vec_t         set_vec;
    err_vec_t         flags;

    mgd_edge_counter #(.CNT_W(CNT_W)) u_edge (
        .mclk   (mclk),
        .rst    (rst),
        .gray_q (mclk_gray)
    );

    mgd_window_meter #(
        .CNT_W       (CNT_W),
        .WIN_LEN     (WIN_LEN),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_meter (
        .clk       (clk),
        .rst       (rst),
        .mclk_gray (mclk_gray),
        .cnt_min   (cnt_min),
        .cnt_max   (cnt_max),
        .meas_cnt  (meas_cnt),
        .meas_vld  (meas_vld),
        .range_hit (range_hit)
    );

    always_comb begin
        set_vec            = '0;
        set_vec[ERR_PROTO] = err_proto;
        set_vec[ERR_UNDER] = err_under;
        set_vec[ERR_OVER]  = err_over;
        set_vec[ERR_RANGE] = range_hit;
    end

    mgd_err_combiner u_comb (
        .clk      (clk),
        .rst      (rst),
        .set_vec  (set_vec),
        .clr_vec  (flag_clr),
        .mute_en  (mute_en),
        .irq_en   (irq_en),
        .ext_mute (ext_mute),
        .mute_pol (mute_pol),
        .flags    (flags),
        .mute_out (mute_out),
        .irq      (irq)
    );

    assign err_flags = flags;

endmodule

// File: tb/mclk_guard_tb.sv
`timescale 1ns/1ps
module mclk_guard_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mclk = 1'b0;
    logic       err_proto = 1'b0, err_under = 1'b0, err_over = 1'b0;
    logic       ext_mute = 1'b0;
    logic [7:0] cnt_min = 8'd0, cnt_max = 8'd255;
    logic [3:0] mute_en = 4'd0, irq_en = 4'd0, flag_clr = 4'd0;
    logic       mute_pol = 1'b1;
    logic [7:0] meas_cnt;
    logic       meas_vld;
    logic [3:0] err_flags;
    logic       mute_out, irq;

    int total = 0;
    int fails = 0;
    bit done  = 0;
    int mclk_half = 2;
    int exp_q[$];

    mclk_guard u_dut (
        .clk(clk), .rst(rst), .mclk(mclk),
        .err_proto(err_proto), .err_under(err_under), .err_over(err_over),
        .ext_mute(ext_mute), .cnt_min(cnt_min), .cnt_max(cnt_max),
        .mute_en(mute_en), .irq_en(irq_en), .mute_pol(mute_pol),
        .flag_clr(flag_clr), .meas_cnt(meas_cnt), .meas_vld(meas_vld),
        .err_flags(err_flags), .mute_out(mute_out), .irq(irq)
    );

    always #4 clk = ~clk;

    // master clock: all edges on odd ns, never on a system clock edge
    initial begin
        #1;
        forever begin
            if (mclk_half == 0) begin
                mclk = 1'b0;
                #2;
            end else begin
                #(mclk_half) mclk = ~mclk;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // monitor: compare each published count against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (meas_vld && exp_q.size() > 0) begin
                int e;
                e = exp_q.pop_front();
                check((int'(meas_cnt) >= e - 1) && (int'(meas_cnt) <= e + 1),
                      "R1 window count", meas_cnt, e);
            end
        end
    end

    task automatic wait_windows(input int n);
        repeat (n) begin
            @(negedge clk);
            while (!meas_vld) @(negedge clk);
        end
    endtask

    task automatic expect_counts(input int e, input int n);
        wait_windows(3);
        @(posedge clk);
        repeat (n) exp_q.push_back(e);
        while (exp_q.size() > 0) @(negedge clk);
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: err_proto = 1'b1;
            1: err_under = 1'b1;
            default: err_over = 1'b1;
        endcase
        @(negedge clk);
        err_proto = 1'b0; err_under = 1'b0; err_over = 1'b0;
    endtask

    task automatic clear(input logic [3:0] m);
        @(negedge clk);
        flag_clr = m;
        @(negedge clk);
        flag_clr = 4'd0;
    endtask

    initial begin
        repeat (6) @(negedge clk);
        check(err_flags == 4'd0 && meas_cnt == 8'd0 && !meas_vld && !irq && !mute_out,
              "R9 reset state", {err_flags, meas_cnt}, 0);
        rst = 1'b0;

        expect_counts(64, 2);   // R1 at 2x master clock

        // R2: value holds inside a window
        begin
            logic [7:0] a;
            wait_windows(1);
            repeat (3) @(negedge clk);
            a = meas_cnt;
            repeat (20) @(negedge clk);
            check(meas_cnt == a, "R2 count held", meas_cnt, a);
        end

        cnt_min = 8'd10; cnt_max = 8'd100;
        wait_windows(2);
        @(negedge clk);
        check(err_flags[3] == 1'b0, "R3 in range no flag", err_flags[3], 0);

        pulse(0);
        check(err_flags == 4'b0001, "R4 protocol sets bit 0", err_flags, 1);
        repeat (6) @(negedge clk);
        check(err_flags == 4'b0001, "R4 sticky", err_flags, 1);
        pulse(2);
        check(err_flags == 4'b0101, "R4 overrun sets bit 2", err_flags, 5);

        clear(4'b0001);
        check(err_flags == 4'b0100, "R5 clear bit 0", err_flags, 4);
        clear(4'b0010);
        check(err_flags == 4'b0100, "R5 clear of zero bit", err_flags, 4);
        @(negedge clk);
        err_over = 1'b1; flag_clr = 4'b0100;
        @(negedge clk);
        err_over = 1'b0; flag_clr = 4'd0;
        check(err_flags == 4'b0100, "R5 set wins over clear", err_flags, 4);
        clear(4'b0100);
        check(err_flags == 4'b0000, "R5 clear bit 2", err_flags, 0);

        mute_en = 4'b0010; irq_en = 4'b0100;
        pulse(1);
        #1;
        check(mute_out == 1'b1, "R6 enabled flag mutes", mute_out, 1);
        check(irq == 1'b0, "R8 irq masked", irq, 0);
        mute_pol = 1'b0;
        #1;
        check(mute_out == 1'b0, "R7 active-low mute", mute_out, 0);
        mute_pol = 1'b1;
        pulse(2);
        #1;
        check(irq == 1'b1, "R8 enabled flag raises irq", irq, 1);
        clear(4'b0111);
        #1;
        check(mute_out == 1'b0 && irq == 1'b0, "R6 cleared no mute", {mute_out, irq}, 0);
        ext_mute = 1'b1;
        #1;
        check(mute_out == 1'b1, "R6 external mute", mute_out, 1);
        ext_mute = 1'b0;

        mclk_half = 4;
        expect_counts(32, 2);
        mclk_half = 8;
        expect_counts(16, 2);
        @(negedge clk);
        check(err_flags[3] == 1'b0, "R3 16 within 10..100", err_flags[3], 0);

        cnt_min = 8'd20;
        wait_windows(2);
        @(negedge clk);
        check(err_flags[3] == 1'b1, "R3 below minimum", err_flags[3], 1);
        irq_en = 4'b1000;
        #1;
        check(irq == 1'b1, "R8 range irq", irq, 1);

        cnt_min = 8'd1;
        mclk_half = 0;
        clear(4'b1000);
        expect_counts(0, 1);
        @(negedge clk);
        check(err_flags[3] == 1'b1, "R10 stopped clock flags range", err_flags[3], 1);

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule